// File: doc/BRIEF.md
# Bus Port Halt Sequencer

This block quiesces a set of bus master ports ahead of a subsystem reset. A single command pulse walks the ports one at a time in a fixed order: port 0 (the processor port), then port 1 (the modem port), then port 2 (the non-coherent port). For each port it first looks at the port's idle indication. A port that is already idle is passed over without any request. Otherwise the block raises that port's halt request and holds it until the port acknowledges or a cycle-count timeout expires. Either way it then samples idle once more, records a per-port failure if the port is still busy, and drops the request. The port is expected to stay halted until the reset that follows.

A timeout never aborts the sequence: the remaining ports are still processed. When the last port has been handled, a one-cycle done pulse is issued. The failure bits stay readable until the next command is accepted.

The controller is a five-state machine:
- `ST_IDLE` waits for a command. On a command it goes to `ST_CHECK` at port 0.
- `ST_CHECK` tests idle on the current port. If the port is idle it moves to the next port, or to `ST_DONE` after the last one. If not, it goes to `ST_WAIT`.
- `ST_WAIT` holds the request until acknowledge or timeout, then goes to `ST_SAMPLE`.
- `ST_SAMPLE` keeps the request, samples idle and records any failure. It then moves to the next port's `ST_CHECK`, or to `ST_DONE`.
- `ST_DONE` pulses done and returns to `ST_IDLE`.

Top module: `bus_halt_seq`

## Requirements
- R1: After reset, `halt_req`, `fail`, `busy` and `done` are all 0.
- R2: A `halt_cmd` is accepted only while the block is not busy (`busy` low). A command seen while busy has no effect on the sequence in progress.
- R3: Ports are handled strictly in ascending index order (bit 0, then bit 1, then bit 2). No two bits of `halt_req` are ever high in the same cycle.
- R4: A port whose `port_idle` bit is 1 when it is examined gets no request and no failure bit.
- R5: For a busy port, the request is held until that port's `port_ack` is seen. If ack is first seen on the d-th cycle of the request (d ≤ `TIMEOUT_CYCLES`), the request is high for exactly d+1 cycles.
- R6: Without an acknowledge, the request is high for exactly `TIMEOUT_CYCLES`+1 cycles. The sequence then continues with the idle check and the later ports; it is not aborted.
- R7: Idle is sampled in the last cycle of the request. If it is 0, bit i of `fail` is set for port i. If it is 1, the bit stays 0.
- R8: After the sample the request returns to 0. While the block is not busy, no request is ever high.
- R9: After the last port, `done` is high for exactly one cycle, and `busy` is low in the following cycle.
- R10: `fail` holds its value after the sequence ends, until the next accepted command clears it (`fail` reads 0 in the cycle after acceptance).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_cmd | input | 1 | Start a halt sequence (sampled when not busy) |
| port_idle | input | NUM_PORTS | Per-port idle indication from the fabric |
| port_ack | input | NUM_PORTS | Per-port halt acknowledge |
| halt_req | output | NUM_PORTS | Per-port halt request, at most one bit high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when all ports are processed |
| fail | output | NUM_PORTS | Per-port halt failure bits, held until next command |

## Verification
A wrong port index shows up within a cycle or two, as a request on the wrong `halt_req` bit or a failure recorded against the wrong port. A stuck or miscounted timeout changes the request length, which is visible as soon as the request drops, `TIMEOUT_CYCLES`+1 cycles after it rose. A state machine that fails to return to idle shows as a missing or repeated `done` pulse, or as `busy` still high one cycle after `done`. A lost failure bit shows at the latest when `fail` is read after the sequence ends.

// File: rtl/bhs_pkg.sv
package bhs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_DONE   = 3'd4
    } hs_state_e;
endpackage

// File: rtl/bhs_port_sel.sv
module bhs_port_sel #(
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 2
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 req_on,
    input  logic [NUM_PORTS-1:0] port_idle,
    input  logic [NUM_PORTS-1:0] port_ack,
    output logic                 sel_idle,
    output logic                 sel_ack,
    output logic [NUM_PORTS-1:0] halt_req
);
    logic [NUM_PORTS-1:0] hit;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
        assign hit[g]      = (idx == IDX_W'(g));
        assign halt_req[g] = hit[g] & req_on;
    end

    assign sel_idle = |(hit & port_idle);
    assign sel_ack  = |(hit & port_ack);
endmodule

// File: rtl/bhs_timer.sv
module bhs_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CNT_W'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/bhs_fail_bank.sv
module bhs_fail_bank #(
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 set,
    input  logic [IDX_W-1:0]     set_idx,
    output logic [NUM_PORTS-1:0] fail
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fail[g] <= 1'b0;
            end else if (clr) begin
                fail[g] <= 1'b0;
            end else if (set && (set_idx == IDX_W'(g))) begin
                fail[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_halt_seq.sv
module bus_halt_seq
    import bhs_pkg::*;
#(
    parameter int NUM_PORTS      = 3,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 halt_cmd,
    input  logic [NUM_PORTS-1:0] port_idle,
    input  logic [NUM_PORTS-1:0] port_ack,
    output logic [NUM_PORTS-1:0] halt_req,
    output logic                 busy,
    output logic                 done,
    output logic [NUM_PORTS-1:0] fail
);
    localparam int               IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

    hs_state_e        state, state_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             sel_idle, sel_ack, tmr_expired;
    logic             req_on, fail_set, fail_clr, tmr_run;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        idx_n   = idx;
        unique case (state)
            ST_IDLE: begin
                if (halt_cmd) begin
                    state_n = ST_CHECK;
                    idx_n   = '0;
                end
            end
            ST_CHECK: begin
                if (!sel_idle) begin
                    state_n = ST_WAIT;
                end else if (idx == LAST_IDX) begin
                    state_n = ST_DONE;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            ST_WAIT: begin
                if (sel_ack || tmr_expired) begin
                    state_n = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (idx == LAST_IDX) begin
                    state_n = ST_DONE;
                end else begin
                    state_n = ST_CHECK;
                    idx_n   = idx + 1'b1;
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_on   = (state == ST_WAIT) || (state == ST_SAMPLE);
        tmr_run  = (state == ST_WAIT);
        fail_set = (state == ST_SAMPLE) && !sel_idle;
        fail_clr = (state == ST_IDLE) && halt_cmd;
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
    end

    bhs_port_sel #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_sel (
        .idx      (idx),
        .req_on   (req_on),
        .port_idle(port_idle),
        .port_ack (port_ack),
        .sel_idle (sel_idle),
        .sel_ack  (sel_ack),
        .halt_req (halt_req)
    );

    bhs_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    bhs_fail_bank #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_fail (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (fail_clr),
        .set    (fail_set),
        .set_idx(idx),
        .fail   (fail)
    );
endmodule

// File: rtl/bhs_checker.sv
module bhs_checker #(
    parameter int NUM_PORTS      = 3,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 halt_cmd,
    input logic [NUM_PORTS-1:0] port_idle,
    input logic [NUM_PORTS-1:0] halt_req,
    input logic                 busy,
    input logic                 done,
    input logic [NUM_PORTS-1:0] fail
);
    localparam int RW = $clog2(TIMEOUT_CYCLES + 3);

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (halt_req == '0) begin
            run_cnt <= '0;
        end else if (run_cnt != {RW{1'b1}}) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R3
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_req));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !halt_cmd) |=> $stable(fail));

    // R7
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fail & ~$past(fail))) |->
        ((fail & ~$past(fail)) == ($past(halt_req) & ~$past(port_idle))));

    // R6
    req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RW'(TIMEOUT_CYCLES + 1));

    // R8
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (halt_req == '0 && !done));
endmodule

bind bus_halt_seq bhs_checker #(
    .NUM_PORTS     (NUM_PORTS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_bhs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_cmd (halt_cmd),
    .port_idle(port_idle),
    .halt_req (halt_req),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
);

// File: tb/bus_halt_seq_bench.sv
`timescale 1ns/1ps
module bus_halt_seq_bench;
    localparam int NP = 3;
    localparam int T  = 12;

    // Vector: {mode2, mode1, mode0, dly2, dly1, dly0}
    // mode 0 idle at once, 1 ack after dly then idle, 2 ack after dly but busy,
    // 3 never ack and busy, 4 never ack but idle after 2 request cycles
    localparam int NV = 6;
    localparam logic [20:0] VEC [NV] = '{
        {3'd0, 3'd0, 3'd0, 4'd0, 4'd0, 4'd0},
        {3'd1, 3'd1, 3'd1, 4'd5, 4'd3, 4'd1},
        {3'd3, 3'd1, 3'd2, 4'd0, 4'd2, 4'd4},
        {3'd4, 3'd0, 3'd3, 4'd0, 4'd0, 4'd0},
        {3'd0, 3'd2, 3'd1, 4'd0, 4'd7, 4'd12},
        {3'd3, 3'd3, 3'd3, 4'd0, 4'd0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_cmd = 1'b0;
    logic [NP-1:0] port_idle = '0;
    logic [NP-1:0] port_ack = '0;
    logic [NP-1:0] halt_req;
    logic          busy, done;
    logic [NP-1:0] fail;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bus_halt_seq #(.NUM_PORTS(NP), .TIMEOUT_CYCLES(T)) u_bus_halt_seq (
        .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd),
        .port_idle(port_idle), .port_ack(port_ack),
        .halt_req(halt_req), .busy(busy), .done(done), .fail(fail)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic int exp_len(input int m, input int d);
        if (m == 0) return 0;
        if (m == 1 || m == 2) return d + 1;
        return T + 1;
    endfunction

    task automatic run_vec(input logic [20:0] v, input int vi);
        int mode [NP];
        int dly  [NP];
        int rcnt [NP];
        int first[NP];
        logic [NP-1:0] exp_fail;
        logic [NP-1:0] fail_at_done;
        int done_cnt;
        int done_at;
        bit overlap;
        int last_first;
        bit order_ok;
        exp_fail = '0;
        for (int i = 0; i < NP; i++) begin
            mode[i]  = int'(v[12 + 3*i +: 3]);
            dly[i]   = int'(v[4*i +: 4]);
            rcnt[i]  = 0;
            first[i] = -1;
            exp_fail[i] = (mode[i] == 2 || mode[i] == 3);
        end
        done_cnt = 0; done_at = -1; overlap = 0; fail_at_done = '0;
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            port_idle[i] = (mode[i] == 0);
            port_ack[i]  = 1'b0;
        end
        halt_cmd = 1'b1;
        @(negedge clk);
        halt_cmd = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (c == 0) check(fail == '0, $sformatf("R10 clear v%0d", vi), int'(fail), 0);
            if (c == 0) check(busy == 1'b1, $sformatf("R2 accept v%0d", vi), int'(busy), 1);
            halt_cmd = (c == 1);
            if ($countones(halt_req) > 1) overlap = 1;
            if (done) begin
                done_cnt++;
                if (done_at < 0) begin done_at = c; fail_at_done = fail; end
            end
            if (done_at >= 0 && c == done_at + 1) begin
                check(busy == 1'b0, $sformatf("R9 busy low v%0d", vi), int'(busy), 0);
                check(halt_req == '0, $sformatf("R8 req low v%0d", vi), int'(halt_req), 0);
            end
            for (int i = 0; i < NP; i++) begin
                if (halt_req[i]) begin
                    rcnt[i]++;
                    if (first[i] < 0) first[i] = c;
                end
                if ((mode[i] == 1 || mode[i] == 2) && rcnt[i] >= dly[i] && rcnt[i] > 0) begin
                    port_ack[i] = 1'b1;
                    if (mode[i] == 1) port_idle[i] = 1'b1;
                end
                if (mode[i] == 4 && rcnt[i] >= 2) port_idle[i] = 1'b1;
            end
            @(negedge clk);
            if (done_at >= 0 && c >= done_at + 3) break;
        end
        halt_cmd = 1'b0;
        check(done_cnt == 1, $sformatf("R2/R9 done pulses v%0d", vi), done_cnt, 1);
        check(!overlap, $sformatf("R3 overlap v%0d", vi), int'(overlap), 0);
        last_first = -1; order_ok = 1;
        for (int i = 0; i < NP; i++) begin
            check(rcnt[i] == exp_len(mode[i], dly[i]),
                  $sformatf("R4/R5/R6 req length v%0d port%0d", vi, i), rcnt[i], exp_len(mode[i], dly[i]));
            if (first[i] >= 0) begin
                if (first[i] <= last_first) order_ok = 0;
                last_first = first[i];
            end
        end
        check(order_ok, $sformatf("R3 order v%0d", vi), int'(order_ok), 1);
        check(fail_at_done == exp_fail, $sformatf("R7 fail v%0d", vi), int'(fail_at_done), int'(exp_fail));
        repeat (6) @(negedge clk);
        check(fail == exp_fail, $sformatf("R10 hold v%0d", vi), int'(fail), int'(exp_fail));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(halt_req == '0, "R1 halt_req", int'(halt_req), 0);
        check(fail == '0, "R1 fail", int'(fail), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VEC[k], k);
        // R4 directed: all idle ports end in four cycles with no request
        run_vec({3'd0, 3'd0, 3'd0, 12'd0}, 99);
        summary();
    end
endmodule